// File: doc/BRIEF.md
# Adjustable PTP Time Counter

This block keeps the time of day for a precision-time-protocol clock as a 40-bit nanosecond count. On every tick of an 8 ns core clock the count grows by a fixed step of 8. The rate is trimmed by a signed sub-nanosecond increment. A 32-bit fractional accumulator adds the trim magnitude on every tick. Each carry out of the accumulator adds one nanosecond to that tick's step or removes one, depending on the sign of the trim.

Software reaches the counter through a small word-wide register port. Reading the sub-nanosecond word freezes a copy of the whole count, so the low and high words that follow form one coherent value while counting continues. A new time is written low word first. The high-word write then loads both words at once and clears the accumulator. A disable flag in the auxiliary control word stops counting and is set out of reset.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the count, the fractional accumulator and the rate word are zero and counting is disabled: AUX reads 0x80000000 and the LO, HI, RATE and SUB words read 0.
- R2: While AUX bit 31 is 1 the count and the accumulator hold their values.
- R3: While AUX bit 31 is 0 and RATE is zero, the count grows by exactly 8 on every clock.
- R4: Word map: address 0 SUB (accumulator), 1 LO (count bits 31:0), 2 HI (count bits 39:32 in bits 7:0), 3 RATE, 4 AUX. A read strobe returns its word on reg_rdata from the next clock on. Addresses 5 to 7 read 0.
- R5: RATE bits 30:0 are a magnitude that is added to the accumulator on each counting clock. A carry out with RATE bit 31 = 0 makes that step 9.
- R6: A carry out with RATE bit 31 = 1 makes that step 7.
- R7: A SUB read captures the whole count at that clock. Later LO and HI reads return the captured value, not the running count.
- R8: HI reads return zero in bits 31:8, and the 40-bit count wraps from its top to zero modulo 2^40.
- R9: A LO write only stages its data. A HI write loads the count with {wdata[7:0], staged LO} and clears the accumulator in the same clock. Counting resumes from the loaded value on the next clock.
- R10: Writes to SUB have no effect, and AUX bits 30:0 are ignored and read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, one tick per 8 ns |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one clock |
| reg_rd | input | 1 | Read strobe for one clock |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after reg_rd |

## Verification
A corrupted accumulator shows up as a wrong step. The error appears within one clock when the carry is missed or inverted, or as a drifted SUB value at the next read. A stale or missing snapshot appears at the first LO or HI read after a SUB read, because the count has moved by then. A faulty commit path shows up on the first read after the HI write, either as a wrong loaded value or as a non-zero accumulator.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  parameter int TC_NS_W     = 40;
  parameter int TC_DATA_W   = 32;
  parameter int TC_FRAC_W   = 32;
  parameter int TC_ADDR_W   = 3;
  parameter int TC_NOM_STEP = 8;

  localparam logic [TC_ADDR_W-1:0] TC_A_SUB  = 3'd0;
  localparam logic [TC_ADDR_W-1:0] TC_A_LO   = 3'd1;
  localparam logic [TC_ADDR_W-1:0] TC_A_HI   = 3'd2;
  localparam logic [TC_ADDR_W-1:0] TC_A_RATE = 3'd3;
  localparam logic [TC_ADDR_W-1:0] TC_A_AUX  = 3'd4;

  typedef enum logic [1:0] {
    STEP_NOMINAL = 2'b00,
    STEP_PLUS    = 2'b01,
    STEP_MINUS   = 2'b10
  } step_sel_e;
endpackage

// File: rtl/tc_frac_accum.sv
module tc_frac_accum #(
  parameter int FRAC_W = ptp_tc_pkg::TC_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              clear,
  input  logic [FRAC_W-2:0] mag,
  output logic [FRAC_W-1:0] frac_q,
  output logic              carry
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    sum   = {1'b0, frac_q} + {2'b00, mag};
    carry = tick_en & sum[FRAC_W];
    if (clear)
      frac_d = '0;
    else if (tick_en)
      frac_d = sum[FRAC_W-1:0];
    else
      frac_d = frac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frac_q <= '0;
    else
      frac_q <= frac_d;
  end
endmodule

// File: rtl/tc_ns_counter.sv
module tc_ns_counter
  import ptp_tc_pkg::*;
#(
  parameter int NS_W     = TC_NS_W,
  parameter int NOM_STEP = TC_NOM_STEP
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            carry,
  input  logic            neg,
  input  logic            load,
  input  logic [NS_W-1:0] load_val,
  output logic [NS_W-1:0] ns_q
);
  localparam logic [NS_W-1:0] STEP_NOM = NS_W'(NOM_STEP);
  localparam logic [NS_W-1:0] STEP_UP  = NS_W'(NOM_STEP + 1);
  localparam logic [NS_W-1:0] STEP_DN  = NS_W'(NOM_STEP - 1);

  step_sel_e       sel;
  logic [NS_W-1:0] step;
  logic [NS_W-1:0] ns_d;

  always_comb begin
    if (carry && !neg)
      sel = STEP_PLUS;
    else if (carry && neg)
      sel = STEP_MINUS;
    else
      sel = STEP_NOMINAL;
  end

  always_comb begin
    case (sel)
      STEP_PLUS:  step = STEP_UP;
      STEP_MINUS: step = STEP_DN;
      default:    step = STEP_NOM;
    endcase
  end

  always_comb begin
    if (load)
      ns_d = load_val;
    else if (tick_en)
      ns_d = ns_q + step;
    else
      ns_d = ns_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ns_q <= '0;
    else
      ns_q <= ns_d;
  end
endmodule

// File: rtl/tc_reg_if.sv
module tc_reg_if
  import ptp_tc_pkg::*;
#(
  parameter int NS_W   = TC_NS_W,
  parameter int DATA_W = TC_DATA_W,
  parameter int FRAC_W = TC_FRAC_W,
  parameter int ADDR_W = TC_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [NS_W-1:0]   ns_q,
  input  logic [FRAC_W-1:0] frac_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              commit,
  output logic [NS_W-1:0]   load_val,
  output logic [FRAC_W-2:0] rate_mag,
  output logic              rate_neg,
  output logic              timer_off
);
  localparam int HI_W = NS_W - DATA_W;

  logic [DATA_W-1:0] stage_lo_q, stage_lo_d;
  logic [DATA_W-1:0] rate_q, rate_d;
  logic              off_q, off_d;
  logic [NS_W-1:0]   snap_q, snap_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              wr_lo, wr_hi, wr_rate, wr_aux, rd_sub;

  // address decode
  always_comb begin
    wr_lo   = reg_wr && (reg_addr == TC_A_LO);
    wr_hi   = reg_wr && (reg_addr == TC_A_HI);
    wr_rate = reg_wr && (reg_addr == TC_A_RATE);
    wr_aux  = reg_wr && (reg_addr == TC_A_AUX);
    rd_sub  = reg_rd && (reg_addr == TC_A_SUB);
  end

  // next-state for the stored words
  always_comb begin
    stage_lo_d = wr_lo   ? reg_wdata : stage_lo_q;
    rate_d     = wr_rate ? reg_wdata : rate_q;
    off_d      = wr_aux  ? reg_wdata[DATA_W-1] : off_q;
    snap_d     = rd_sub  ? ns_q : snap_q;
  end

  // read multiplexer, returns the word selected in the strobe cycle
  always_comb begin
    case (reg_addr)
      TC_A_SUB:  rdata_d = DATA_W'(frac_q);
      TC_A_LO:   rdata_d = snap_q[DATA_W-1:0];
      TC_A_HI:   rdata_d = DATA_W'(snap_q[NS_W-1:DATA_W]);
      TC_A_RATE: rdata_d = rate_q;
      TC_A_AUX:  rdata_d = {off_q, {(DATA_W-1){1'b0}}};
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q <= '0;
      rate_q     <= '0;
      off_q      <= 1'b1;
      snap_q     <= '0;
    end else begin
      stage_lo_q <= stage_lo_d;
      rate_q     <= rate_d;
      off_q      <= off_d;
      snap_q     <= snap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (reg_rd)
      rdata_q <= rdata_d;
  end

  always_comb begin
    reg_rdata = rdata_q;
    commit    = wr_hi;
    load_val  = {reg_wdata[HI_W-1:0], stage_lo_q};
    rate_mag  = rate_q[FRAC_W-2:0];
    rate_neg  = rate_q[DATA_W-1];
    timer_off = off_q;
  end
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int NS_W     = TC_NS_W,
  parameter int DATA_W   = TC_DATA_W,
  parameter int FRAC_W   = TC_FRAC_W,
  parameter int ADDR_W   = TC_ADDR_W,
  parameter int NOM_STEP = TC_NOM_STEP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W-1:0] frac_q;
  logic              commit;
  logic [NS_W-1:0]   load_val;
  logic [FRAC_W-2:0] rate_mag;
  logic              rate_neg;
  logic              timer_off;
  logic              tick_en;
  logic              carry;

  // a load takes precedence over the tick of the same clock
  assign tick_en = !timer_off && !commit;

  tc_reg_if #(
    .NS_W(NS_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ns_q(ns_q), .frac_q(frac_q),
    .reg_rdata(reg_rdata), .commit(commit), .load_val(load_val),
    .rate_mag(rate_mag), .rate_neg(rate_neg), .timer_off(timer_off)
  );

  tc_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clear(commit),
    .mag(rate_mag), .frac_q(frac_q), .carry(carry)
  );

  tc_ns_counter #(.NS_W(NS_W), .NOM_STEP(NOM_STEP)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .carry(carry),
    .neg(rate_neg), .load(commit), .load_val(load_val), .ns_q(ns_q)
  );
endmodule

// File: rtl/tc_checker.sv
module tc_checker
  import ptp_tc_pkg::*;
#(
  parameter int NS_W     = TC_NS_W,
  parameter int DATA_W   = TC_DATA_W,
  parameter int FRAC_W   = TC_FRAC_W,
  parameter int ADDR_W   = TC_ADDR_W,
  parameter int NOM_STEP = TC_NOM_STEP
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic                   reg_rd,
  input logic [ADDR_W-1:0]      reg_addr,
  input logic                   wdata_top,
  input logic [DATA_W-1:NS_W-DATA_W] rdata_upper,
  input logic [NS_W-1:0]        ns_q,
  input logic [FRAC_W-1:0]      frac_q,
  input logic                   timer_off
);
  logic load_req;
  assign load_req = reg_wr && (reg_addr == TC_A_HI);

  // R2: disabled timer holds the count
  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(timer_off) && !$past(load_req)) |-> (ns_q == $past(ns_q)));

  // R3 R5 R6: every counting step is the nominal step or one away from it
  assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(timer_off) && !$past(load_req)) |->
      ((ns_q - $past(ns_q)) == NS_W'(NOM_STEP) ||
       (ns_q - $past(ns_q)) == NS_W'(NOM_STEP + 1) ||
       (ns_q - $past(ns_q)) == NS_W'(NOM_STEP - 1)));

  // R9: a high-word write clears the accumulator
  assert_commit_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load_req)) |-> (frac_q == '0));

  // R8: reserved high bits read zero
  assert_hi_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_rd && reg_addr == TC_A_HI)) |-> (rdata_upper == '0));

  // R10: only the top AUX bit controls counting
  assert_aux_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr && reg_addr == TC_A_AUX)) |-> (timer_off == $past(wdata_top)));
endmodule

bind ptp_time_counter tc_checker #(
  .NS_W(NS_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .NOM_STEP(NOM_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .wdata_top(reg_wdata[DATA_W-1]), .rdata_upper(reg_rdata[DATA_W-1:NS_W-DATA_W]),
  .ns_q(ns_q), .frac_q(frac_q), .timer_off(timer_off)
);

// File: tb/ptp_time_counter_test.sv
module ptp_time_counter_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int tests_run;
  int tests_failed;
  string cur_req;

  typedef struct {
    logic [31:0] value;
    string       req;
  } exp_item_t;
  exp_item_t exp_q[$];

  ptp_time_counter uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference state kept from the requirements
  logic [39:0] m_ns, m_snap;
  logic [31:0] m_frac, m_rate, m_stage;
  logic        m_off;
  logic        m_pend;

  always @(posedge clk) begin
    logic [32:0] s;
    exp_item_t   it;
    if (!rst_n) begin
      m_ns = '0; m_snap = '0; m_frac = '0; m_rate = '0; m_stage = '0;
      m_off = 1'b1; m_pend = 1'b0;
    end else begin
      m_pend = reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          3'd0: begin it.value = m_frac; m_snap = m_ns; end
          3'd1: it.value = m_snap[31:0];
          3'd2: it.value = {24'h0, m_snap[39:32]};
          3'd3: it.value = m_rate;
          3'd4: it.value = {m_off, 31'h0};
          default: it.value = 32'h0;
        endcase
        it.req = cur_req;
        exp_q.push_back(it);
      end
      if (reg_wr && reg_addr == 3'd2) begin
        m_ns = {reg_wdata[7:0], m_stage};
        m_frac = '0;
      end else if (!m_off) begin
        s = {1'b0, m_frac} + {2'b00, m_rate[30:0]};
        m_frac = s[31:0];
        if (s[32] && !m_rate[31])      m_ns = m_ns + 40'd9;
        else if (s[32] && m_rate[31])  m_ns = m_ns + 40'd7;
        else                           m_ns = m_ns + 40'd8;
      end
      if (reg_wr && reg_addr == 3'd1) m_stage = reg_wdata;
      if (reg_wr && reg_addr == 3'd3) m_rate  = reg_wdata;
      if (reg_wr && reg_addr == 3'd4) m_off   = reg_wdata[31];
    end
  end

  // monitor: compares each read result away from the active edge
  always @(negedge clk) begin
    exp_item_t it;
    if (rst_n && m_pend) begin
      tests_run++;
      if (exp_q.size() == 0) begin
        tests_failed++;
        $display("FAIL %s: unexpected read result %h, expected none", cur_req, reg_rdata);
      end else begin
        it = exp_q.pop_front();
        if (reg_rdata !== it.value) begin
          tests_failed++;
          $display("FAIL %s: rdata %h expected %h", it.req, reg_rdata, it.value);
        end
      end
    end
  end

  task automatic do_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, input string req);
    @(negedge clk);
    cur_req = req;
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  endtask

  initial begin
    #800000;
    tests_failed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    tests_run = 0; tests_failed = 0; cur_req = "R1";
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    do_read(3'd4, "R1");
    do_read(3'd0, "R1");
    do_read(3'd1, "R1");
    do_read(3'd2, "R1");
    do_read(3'd3, "R1");
    // R4 unmapped
    do_read(3'd6, "R4");
    // R2 disabled timer holds
    idle(6);
    do_read(3'd0, "R2");
    do_read(3'd1, "R2");
    // R10 ignored writes
    do_write(3'd0, 32'hDEAD_BEEF);
    do_read(3'd0, "R10");
    do_write(3'd4, 32'h8000_00FF);
    do_read(3'd4, "R10");
    do_read(3'd1, "R10");
    // R3 nominal counting
    do_write(3'd4, 32'h0000_0000);
    do_read(3'd4, "R4");
    idle(10);
    do_read(3'd0, "R3");
    do_read(3'd1, "R3");
    do_read(3'd2, "R3");
    // R7 snapshot survives while counting continues
    do_read(3'd0, "R7");
    idle(7);
    do_read(3'd1, "R7");
    do_read(3'd1, "R7");
    // R5 positive trim, carry every fourth tick
    do_write(3'd3, 32'h4000_0000);
    do_read(3'd3, "R5");
    idle(21);
    do_read(3'd0, "R5");
    do_read(3'd1, "R5");
    // R6 negative trim
    do_write(3'd3, 32'hC000_0000);
    idle(23);
    do_read(3'd0, "R6");
    do_read(3'd1, "R6");
    do_write(3'd3, 32'h2000_0001);
    idle(17);
    do_read(3'd0, "R5");
    do_read(3'd1, "R5");
    // R9 staged low word, commit on high word
    do_write(3'd3, 32'h0000_0000);
    do_write(3'd1, 32'hFFFF_FFF0);
    idle(3);
    do_read(3'd0, "R9");
    do_read(3'd1, "R9");
    do_write(3'd2, 32'hABCD_12FF);
    do_read(3'd0, "R9");
    do_read(3'd1, "R9");
    do_read(3'd2, "R8");
    // R8 wrap past 2^40
    idle(4);
    do_read(3'd0, "R8");
    do_read(3'd1, "R8");
    do_read(3'd2, "R8");
    // R9 commit clears a non-zero accumulator
    do_write(3'd3, 32'h3000_0000);
    idle(5);
    do_write(3'd1, 32'h0000_1000);
    do_write(3'd2, 32'h0000_0001);
    do_read(3'd0, "R9");
    do_read(3'd1, "R9");
    do_read(3'd2, "R9");
    // R2 disable again
    do_write(3'd4, 32'h8000_0000);
    do_read(3'd0, "R2");
    do_read(3'd1, "R2");
    idle(9);
    do_read(3'd0, "R2");
    do_read(3'd1, "R2");
    do_read(3'd2, "R2");
    idle(3);
    if (exp_q.size() != 0) begin
      tests_failed++;
      $display("FAIL R4: %0d reads without result, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule